// File: doc/BRIEF.md
# Double-Buffered Converter Register Front-End

This block is the digital input section of a 14-bit segmented current-steering converter, rebuilt as clocked logic. A host drives a 14-bit parallel word and three active-low strobes (select, write, load) that arrive with no relation to the block clock. A first-stage holding register captures the word; a second-stage converter register feeds the switch decoder. Separating the two stages lets several converters be filled one by one and then updated together by a shared load strobe. Driving all three strobes low makes both stages transparent, so a single write reaches the switches at once.

The converter register is split into a 3-bit upper segment and an 11-bit lower segment. The upper segment becomes seven equally weighted thermometer lines. The lower segment drives the binary ladder switches directly. A flag marks the all-zero code, which a gain-control loop built around the converter must never apply.

Each strobe passes through a two-flop synchronizer. The data bus is delayed by the same number of stages plus one, so it stays aligned with the strobes. A four-state mode register (`MODE_IDLE`, `MODE_LOAD`, `MODE_XFER`, `MODE_PASS`) is set every clock from the synchronized strobes and may move from any state to any other. Selection: all three strobes low gives `MODE_PASS`; select and write low with load high gives `MODE_LOAD`; load low with select or write high gives `MODE_XFER`; anything else gives `MODE_IDLE`. The registers act on the state during the following clock.

Top module: `dac_dbuf_front`

## Requirements
- R1: While reset is held, and right after it, both registers are zero: all thermometer lines off, ladder bits zero, zero flag high.
- R2: Select and write low with load high copies the bus into the holding register and leaves the outputs unchanged.
- R3: Load low with select or write high copies the holding register into the converter register.
- R4: Select, write and load all low load the bus into both registers, so the outputs follow the bus and a later transfer keeps the same code.
- R5: Load high with select or write high changes neither register, whatever the bus does.
- R6: When the top 3 bits of the converter register (bits 13..11) equal k, thermometer lines 0 to k-1 are on and the rest are off.
- R7: Ladder bit i equals bit i of the converter register, for bits 10..0.
- R8: The zero flag is high exactly when the converter register holds all zeros.
- R9: A strobe level present at a rising edge takes effect on the outputs right after the third rising edge that follows, with the bus value sampled at that first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe, active low, asynchronous |
| data_i | input | 14 | Parallel data word, bit 13 most significant |
| therm_o | output | 7 | Thermometer switch lines for the upper segment |
| ladder_o | output | 11 | Binary ladder switch bits for the lower segment |
| zero_o | output | 1 | High when the converter register is all zeros |

## Verification
The bench uses the default values: a 14-bit word, a 3-bit upper segment and two synchronizer stages. With these, all eight segment codes, from no lines on to all seven on, can be reached with short directed sweeps. The ladder extremes 0 and 0x7FF are reached as well. The three-edge latency is short enough that a random strobe sequence hits every mode change, including mode changes on back-to-back cycles. This exposes misalignment between the data delay and the strobe synchronizers.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_XFER = 2'd2,
        MODE_PASS = 2'd3
    } dbf_mode_e;

    function automatic dbf_mode_e pick_mode(input logic sel_n, input logic wr_n,
                                            input logic ld_n);
        dbf_mode_e m;
        if (!sel_n && !wr_n && !ld_n)      m = MODE_PASS;
        else if (!sel_n && !wr_n)          m = MODE_LOAD;
        else if (!ld_n)                    m = MODE_XFER;
        else                               m = MODE_IDLE;
        return m;
    endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
    import dbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_n_s,
    input  logic      wr_n_s,
    input  logic      ld_n_s,
    output dbf_mode_e mode,
    output logic      hold_wr,
    output logic      conv_wr,
    output logic      conv_from_bus
);
    dbf_mode_e state_q, state_d;

    always_comb begin
        state_d = pick_mode(sel_n_s, wr_n_s, ld_n_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hold_wr       = 1'b0;
        conv_wr       = 1'b0;
        conv_from_bus = 1'b0;
        unique case (state_q)
            MODE_IDLE: ;
            MODE_LOAD: hold_wr = 1'b1;
            MODE_XFER: conv_wr = 1'b1;
            MODE_PASS: begin
                hold_wr       = 1'b1;
                conv_wr       = 1'b1;
                conv_from_bus = 1'b1;
            end
            default: ;
        endcase
    end

    assign mode = state_q;

    assert_pass_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_s && !wr_n_s && !ld_n_s) |=> (state_q == MODE_PASS));

    assert_idle_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n_s && (sel_n_s || wr_n_s)) |=> (state_q == MODE_IDLE));

endmodule

// File: rtl/dbf_regs.sv
module dbf_regs
    import dbf_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbf_mode_e         mode,
    input  logic              hold_wr,
    input  logic              conv_wr,
    input  logic              conv_from_bus,
    input  logic [DATA_W-1:0] bus_d,
    output logic [DATA_W-1:0] conv_q
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_wr) hold_q <= bus_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       conv_q <= '0;
        else if (conv_wr) conv_q <= conv_from_bus ? bus_d : hold_q;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> ($stable(conv_q) && hold_q == $past(bus_d)));

    assert_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_XFER) |=> (conv_q == $past(hold_q) && $stable(hold_q)));

    assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PASS) |=> (conv_q == $past(bus_d) && hold_q == $past(bus_d)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |=> ($stable(conv_q) && $stable(hold_q)));

endmodule

// File: rtl/dbf_decode.sv
module dbf_decode #(
    parameter int DATA_W   = 14,
    parameter int SEG_BITS = 3,
    parameter int THERM_W  = (2**SEG_BITS) - 1,
    parameter int LADDER_W = DATA_W - SEG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   code,
    output logic [THERM_W-1:0]  therm,
    output logic [LADDER_W-1:0] ladder,
    output logic                is_zero
);
    logic [SEG_BITS-1:0] seg;

    assign seg    = code[DATA_W-1 -: SEG_BITS];
    assign ladder = code[LADDER_W-1:0];

    generate
        for (genvar i = 0; i < THERM_W; i++) begin : g_line
            assign therm[i] = (seg > SEG_BITS'(i));
        end
    endgenerate

    assign is_zero = (seg == '0) && (ladder == '0);

    assert_therm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm & (therm + 1'b1)) == '0) && ($countones(therm) == int'(seg)));

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dbf_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int SEG_BITS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cs_n,
    input  logic                           wr_n,
    input  logic                           ld_n,
    input  logic [DATA_W-1:0]              data_i,
    output logic [(2**SEG_BITS)-2:0]       therm_o,
    output logic [DATA_W-SEG_BITS-1:0]     ladder_o,
    output logic                           zero_o
);
    localparam int THERM_W  = (2**SEG_BITS) - 1;
    localparam int LADDER_W = DATA_W - SEG_BITS;
    localparam int ALIGN    = SYNC_STAGES + 1;

    logic [2:0]        strobe_s;
    logic [DATA_W-1:0] bus_d;
    logic [DATA_W-1:0] conv_q;
    dbf_mode_e         mode;
    logic              hold_wr, conv_wr, conv_from_bus;

    dbf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strobe_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, wr_n, ld_n}),
        .q    (strobe_s)
    );

    dbf_sync #(.WIDTH(DATA_W), .STAGES(ALIGN), .RST_VAL('0)) u_bus_align (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (data_i),
        .q    (bus_d)
    );

    dbf_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n_s      (strobe_s[2]),
        .wr_n_s       (strobe_s[1]),
        .ld_n_s       (strobe_s[0]),
        .mode         (mode),
        .hold_wr      (hold_wr),
        .conv_wr      (conv_wr),
        .conv_from_bus(conv_from_bus)
    );

    dbf_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .hold_wr      (hold_wr),
        .conv_wr      (conv_wr),
        .conv_from_bus(conv_from_bus),
        .bus_d        (bus_d),
        .conv_q       (conv_q)
    );

    dbf_decode #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS),
                 .THERM_W(THERM_W), .LADDER_W(LADDER_W)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (conv_q),
        .therm  (therm_o),
        .ladder (ladder_o),
        .is_zero(zero_o)
    );

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (therm_o == '0 && ladder_o == '0));

    assert_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_o) |-> (therm_o != '0 || ladder_o != '0));

    assert_reset_R1: assert property (@(posedge clk)
        (!rst_n) |-> (therm_o == '0 && ladder_o == '0 && zero_o));

endmodule

// File: tb/test_dac_dbuf_front.sv
module test_dac_dbuf_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [13:0] data_i = '0;
    logic [6:0]  therm_o;
    logic [10:0] ladder_o;
    logic        zero_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dac_dbuf_front i_dac_dbuf_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
        .data_i(data_i), .therm_o(therm_o), .ladder_o(ladder_o), .zero_o(zero_o)
    );

    // behavioural reference: queue of pin samples, applied three edges later
    logic [16:0] pend[$];
    int m_hold = 0;
    int m_conv = 0;

    task automatic model_reset();
        pend.delete();
        for (int i = 0; i < 3; i++) pend.push_back({3'b111, 14'd0});
        m_hold = 0;
        m_conv = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic [16:0] e;
            int d;
            e = pend.pop_front();
            d = int'(e[13:0]);
            if (!e[16] && !e[15] && !e[14]) begin m_hold = d; m_conv = d; end
            else if (!e[16] && !e[15])     m_hold = d;
            else if (!e[14])               m_conv = m_hold;
            pend.push_back({cs_n, wr_n, ld_n, data_i});
        end
    end

    function automatic logic [6:0] exp_therm(int code);
        int k = (code >> 11) & 7;
        return 7'((1 << k) - 1);
    endfunction

    task automatic cmp(string req, logic [6:0] t, logic [10:0] l, logic z);
        checks++;
        if (therm_o !== t || ladder_o !== l || zero_o !== z) begin
            bad++;
            $display("FAIL %s: therm=%h ladder=%h zero=%b expected therm=%h ladder=%h zero=%b",
                     req, therm_o, ladder_o, zero_o, t, l, z);
        end
    endtask

    // per-cycle comparison against the model (R9 latency, plus current phase)
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished)
            cmp({cur_req, "/R9"}, exp_therm(m_conv), 11'(m_conv), m_conv == 0);
    end

    task automatic put(logic c, logic w, logic l, logic [13:0] d, int n);
        @(negedge clk);
        cs_n = c; wr_n = w; ld_n = l; data_i = d;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic spot(string req, int code);
        cmp(req, exp_therm(code), 11'(code), code == 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int unsigned x;
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        spot("R1 during reset", 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        spot("R1 after reset", 0);

        cur_req = "R2";
        put(1'b0, 1'b0, 1'b1, 14'h2ABC, 5);
        put(1'b1, 1'b1, 1'b1, 14'h1111, 5);
        spot("R2 outputs unchanged by input load", 0);

        cur_req = "R3";
        put(1'b1, 1'b0, 1'b0, 14'h0F0F, 5);
        put(1'b1, 1'b1, 1'b1, 14'h0000, 5);
        spot("R3 transfer of 0x2ABC", 14'h2ABC);
        spot("R6 segment 5 lines", 14'h2ABC);
        spot("R7 ladder 0x2BC", 14'h2ABC);

        cur_req = "R5";
        put(1'b0, 1'b1, 1'b1, 14'h3333, 5);
        put(1'b1, 1'b0, 1'b1, 14'h0555, 5);
        put(1'b1, 1'b1, 1'b1, 14'h3FFF, 5);
        spot("R5 no change with strobes idle", 14'h2ABC);
        put(1'b1, 1'b0, 1'b0, 14'h0000, 5);
        put(1'b1, 1'b1, 1'b1, 14'h0000, 4);
        spot("R5 holding register kept 0x2ABC", 14'h2ABC);

        cur_req = "R4";
        put(1'b0, 1'b0, 1'b0, 14'h3FFF, 5);
        spot("R4 pass-through full scale", 14'h3FFF);
        put(1'b0, 1'b0, 1'b0, 14'h0000, 5);
        cur_req = "R8";
        spot("R8 zero flag on all-zero code", 0);
        put(1'b1, 1'b1, 1'b1, 14'h1234, 4);
        put(1'b0, 1'b1, 1'b0, 14'h2222, 5);
        spot("R4 holding register took pass value", 0);
        put(1'b0, 1'b0, 1'b0, 14'h0001, 5);
        spot("R8 flag low on code 1", 1);

        cur_req = "R6";
        for (int k = 0; k < 8; k++) begin
            put(1'b0, 1'b0, 1'b0, 14'((k << 11) | 11'h7FF), 5);
            spot("R6 thermometer sweep", (k << 11) | 11'h7FF);
        end
        cur_req = "R7";
        put(1'b0, 1'b0, 1'b0, 14'h0400, 5);
        spot("R7 ladder msb only", 14'h0400);

        cur_req = "R9";
        put(1'b0, 1'b0, 1'b1, 14'h1357, 1);
        put(1'b1, 1'b1, 1'b0, 14'h0000, 1);
        put(1'b1, 1'b1, 1'b1, 14'h0000, 1);
        spot("R9 before third edge", 14'h0400);
        put(1'b1, 1'b1, 1'b1, 14'h0000, 1);
        spot("R9 after load path", 14'h0400);
        put(1'b1, 1'b1, 1'b1, 14'h0000, 1);
        spot("R9 transfer on third edge", 14'h1357);

        x = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            put(x[20] & x[21], x[22] & x[23], x[24] | x[25], x[13:0], 1);
        end
        put(1'b1, 1'b1, 1'b1, 14'h0000, 6);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule